// File: doc/BRIEF.md
# Descriptor-Driven Bus-Master DMA Engine

This block moves a disk drive's sector data between system memory and the drive without processor involvement. Software places a table of memory segments in memory and writes its base address into a pointer register. It then sets a start bit that also selects the direction. When the drive asks for a transfer of a given byte count, the engine walks the table one segment at a time, reading each segment's address and length. Bytes travel in order between a single memory master port and a byte stream to or from the drive.

The outcome is reported in a small status register and on an interrupt line. The final status code depends on how the total length of the table compares with the drive's byte count. A table that exactly covers the transfer, a table that runs out first and a table that is left over each give a different code. Clearing the start bit partway through changes the code in a fixed way. Each table entry is two little-endian 32-bit words: the segment's byte address, then its byte count. Bit 31 of the count word marks the final entry.

Top module: `prd_dma`

## Requirements
- R1: Register offsets are command at 0, status at 2 and table pointer at 4. Command bit 0 is start and bit 3 is direction, where 1 means drive-to-memory. Status bit 0 is ACTIVE, bit 1 is ERROR and bit 2 is INTERRUPT. All registers read 0 after reset, and setting start sets ACTIVE.
- R2: The pointer register ignores address bits 1:0, which read back as 0. Entries are fetched as 32-bit words from increasing addresses starting at the pointer.
- R3: In drive-to-memory mode, each byte from the drive is written, byte by byte, to consecutive addresses of the current segment.
- R4: In memory-to-drive mode, bytes are read from the segments in table order and delivered to the drive in that order.
- R5: If the table exactly covers the drive's byte count, the final status is 0x04 (INTERRUPT only).
- R6: If the final entry is consumed before the drive's count is reached, the status becomes 0x00. The remaining drive bytes are then absorbed (accepted, or supplied as 0x00) with no memory access.
- R7: If the drive's count is reached while table length remains, the final status is 0x05 (ACTIVE and INTERRUPT).
- R8: Clearing start clears ACTIVE at once, and no data memory access follows. The final status is then that of R5 to R7 with ACTIVE clear: 0x04 for a long table and 0x00 for a short one.
- R9: A count field (bits 15:0) of zero in an entry means 65536 bytes.
- R10: Writing 1 to status bit 2 clears INTERRUPT, and the irq output always equals INTERRUPT. ERROR is never set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register byte offset for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| drv_req | input | 1 | Drive transfer request pulse |
| drv_len | input | 20 | Drive transfer byte count, captured with drv_req |
| mem_req | output | 1 | Memory access request, held until mem_ack |
| mem_we | output | 1 | 1 = byte write, 0 = read |
| mem_word | output | 1 | 1 = 32-bit table word read, 0 = byte access |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 8 | Memory write byte |
| mem_ack | input | 1 | Access complete; read data valid |
| mem_rdata | input | 32 | Memory read data (byte in bits 7:0) |
| in_valid | input | 1 | Drive byte available |
| in_data | input | 8 | Byte from drive |
| in_ready | output | 1 | Engine accepts a drive byte |
| out_valid | output | 1 | Byte for drive available |
| out_data | output | 8 | Byte to drive |
| out_ready | input | 1 | Drive accepts the byte |
| irq | output | 1 | Interrupt, equal to INTERRUPT status |

## Verification
The hardest case to reach is a stop that arrives before any table entry has been fetched. Even then the engine must still walk the table to decide between the 0x04 and 0x00 outcomes, and it must not touch data memory. The bench sets start and clears it on the next cycle, before it raises the drive request. It then checks that ACTIVE has already dropped. It presets the target buffer to a marker value and afterwards confirms that the marker is intact and the status matches the table length. The zero-count case is reached with a single final entry whose count word has only bit 31 set.

// File: rtl/prd_dma_pkg.sv
package prd_dma_pkg;
   typedef enum logic [2:0] {
      ST_IDLE,
      ST_DESC_A,
      ST_DESC_B,
      ST_MOVE,
      ST_DRAIN
   } eng_state_t;

   localparam logic [2:0] OFS_CMD = 3'd0;
   localparam logic [2:0] OFS_STS = 3'd2;
   localparam logic [2:0] OFS_PTR = 3'd4;

   localparam int CMD_RUN = 0;
   localparam int CMD_DIR = 3;
   localparam int STS_INT = 2;
   localparam int LAST_FLAG = 31;
endpackage

// File: rtl/prd_dma_regs.sv
module prd_dma_regs
   import prd_dma_pkg::*;
#(
   parameter int ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [2:0]        acc_addr,
   input  logic [ADDR_W-1:0] wr_data,
   output logic [ADDR_W-1:0] rd_data,
   input  logic              fin,
   input  logic              fin_intr,
   input  logic              fin_idle,
   output logic              go,
   output logic              stopped,
   output logic              dir,
   output logic [ADDR_W-1:0] tbl_base,
   output logic              irq
);
   logic run_q, act_q, int_q;
   logic cmd_wr, sts_wr, ptr_wr, run_rise, run_fall;

   assign cmd_wr   = wr_en && (acc_addr == OFS_CMD);
   assign sts_wr   = wr_en && (acc_addr == OFS_STS);
   assign ptr_wr   = wr_en && (acc_addr == OFS_PTR);
   assign run_rise = cmd_wr && wr_data[CMD_RUN] && !run_q;
   assign run_fall = cmd_wr && !wr_data[CMD_RUN] && run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run_q    <= 1'b0;
         dir      <= 1'b0;
         act_q    <= 1'b0;
         int_q    <= 1'b0;
         go       <= 1'b0;
         stopped  <= 1'b0;
         tbl_base <= '0;
      end else begin
         if (fin) go <= 1'b0;
         if (fin && fin_idle) act_q <= 1'b0;
         if (cmd_wr) begin
            run_q <= wr_data[CMD_RUN];
            if (!go) dir <= wr_data[CMD_DIR];
         end
         if (run_rise) begin
            act_q   <= 1'b1;
            go      <= 1'b1;
            stopped <= 1'b0;
         end
         if (run_fall) begin
            act_q   <= 1'b0;
            stopped <= 1'b1;
         end
         if (sts_wr && wr_data[STS_INT]) int_q <= 1'b0;
         if (fin && fin_intr) int_q <= 1'b1;
         if (ptr_wr) tbl_base <= {wr_data[ADDR_W-1:2], 2'b00};
      end
   end

   always_comb begin
      case (acc_addr)
         OFS_CMD: rd_data = ADDR_W'({dir, 2'b00, run_q});
         OFS_STS: rd_data = ADDR_W'({int_q, 1'b0, act_q});
         OFS_PTR: rd_data = tbl_base;
         default: rd_data = '0;
      endcase
   end

   assign irq = int_q;

   assert_irq_after_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (fin && fin_intr) |=> irq);
   assert_start_sets_active_R1: assert property (@(posedge clk) disable iff (!rst_n)
      run_rise |=> rd_data[0] || (acc_addr != OFS_STS));
endmodule

// File: rtl/prd_dma_engine.sv
module prd_dma_engine
   import prd_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 20,
   parameter int SEG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  logic              stopped,
   input  logic              dir,
   input  logic [ADDR_W-1:0] tbl_base,
   input  logic              drv_req,
   input  logic [LEN_W-1:0]  drv_len,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [7:0]        out_data,
   input  logic              out_ready,
   output logic              fin,
   output logic              fin_intr,
   output logic              fin_idle
);
   localparam int CNT_W = SEG_W + 1;

   generate
      if (SEG_W > 16 || SEG_W < 4) begin : g_bad_seg
         $error("SEG_W must be 4..16");
      end
      if (LEN_W < 2 || ADDR_W < 8 || ADDR_W > 32) begin : g_bad_w
         $error("LEN_W or ADDR_W out of range");
      end
   endgenerate

   eng_state_t        st;
   logic              pend, last, bvalid, step, drain_step;
   logic [LEN_W-1:0]  rem;
   logic [ADDR_W-1:0] ptr, seg_addr;
   logic [CNT_W-1:0]  seg_cnt;
   logic [7:0]        buf_q;
   logic              unused_rdata;

   assign unused_rdata = ^mem_rdata;
   assign mem_wdata = buf_q;

   always_comb begin
      mem_req = 1'b0; mem_we = 1'b0; mem_word = 1'b0; mem_addr = seg_addr;
      in_ready = 1'b0; out_valid = 1'b0; out_data = buf_q;
      step = 1'b0; drain_step = 1'b0;
      fin = 1'b0; fin_intr = 1'b0; fin_idle = 1'b0;
      case (st)
         ST_DESC_A, ST_DESC_B: begin
            mem_req = 1'b1; mem_word = 1'b1; mem_addr = ptr;
         end
         ST_MOVE: begin
            if (dir) begin
               if (!bvalid) in_ready = 1'b1;
               else begin
                  mem_req = !stopped; mem_we = 1'b1;
                  step = stopped || mem_ack;
               end
            end else begin
               if (!bvalid) mem_req = !stopped;
               else begin
                  out_valid = 1'b1;
                  step = out_ready;
               end
            end
         end
         ST_DRAIN: begin
            if (dir) begin
               in_ready = 1'b1; drain_step = in_valid;
            end else begin
               out_valid = 1'b1; out_data = 8'h00; drain_step = out_ready;
            end
         end
         default: ;
      endcase
      if (step) begin
         if (rem == LEN_W'(1)) begin
            fin = 1'b1; fin_intr = 1'b1;
            fin_idle = (seg_cnt == CNT_W'(1)) && last;
         end else if (seg_cnt == CNT_W'(1) && last) begin
            fin = 1'b1; fin_idle = 1'b1;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= ST_IDLE; pend <= 1'b0; last <= 1'b0; bvalid <= 1'b0;
         rem <= '0; ptr <= '0; seg_addr <= '0; seg_cnt <= '0; buf_q <= '0;
      end else begin
         case (st)
            ST_IDLE: begin
               if (drv_req && drv_len != '0) begin
                  pend <= 1'b1; rem <= drv_len;
               end
               if (pend && go) begin
                  ptr <= tbl_base; bvalid <= 1'b0; st <= ST_DESC_A;
               end
            end
            ST_DESC_A: if (mem_ack) begin
               seg_addr <= mem_rdata[ADDR_W-1:0];
               ptr <= ptr + ADDR_W'(4);
               st <= ST_DESC_B;
            end
            ST_DESC_B: if (mem_ack) begin
               seg_cnt <= (mem_rdata[SEG_W-1:0] == '0) ? (CNT_W'(1) << SEG_W)
                                                       : {1'b0, mem_rdata[SEG_W-1:0]};
               last <= mem_rdata[LAST_FLAG];
               ptr <= ptr + ADDR_W'(4);
               st <= ST_MOVE;
            end
            ST_MOVE: begin
               if (!bvalid) begin
                  if (dir && in_valid) begin
                     buf_q <= in_data; bvalid <= 1'b1;
                  end else if (!dir && (stopped || mem_ack)) begin
                     buf_q <= stopped ? 8'h00 : mem_rdata[7:0]; bvalid <= 1'b1;
                  end
               end
               if (step) begin
                  bvalid   <= 1'b0;
                  rem      <= rem - LEN_W'(1);
                  seg_cnt  <= seg_cnt - CNT_W'(1);
                  seg_addr <= seg_addr + ADDR_W'(1);
                  if (rem == LEN_W'(1)) begin
                     st <= ST_IDLE; pend <= 1'b0;
                  end else if (seg_cnt == CNT_W'(1)) begin
                     st <= last ? ST_DRAIN : ST_DESC_A;
                  end
               end
            end
            ST_DRAIN: if (drain_step) begin
               rem <= rem - LEN_W'(1);
               if (rem == LEN_W'(1)) begin
                  st <= ST_IDLE; pend <= 1'b0;
               end
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assert_desc_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && mem_word) |-> (mem_addr[1:0] == 2'b00));
   assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));
   assert_stop_no_data_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (stopped && mem_req) |-> mem_word);
   assert_one_direction_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));
   assert_drain_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_DRAIN) |-> !mem_req);
endmodule

// File: rtl/prd_dma.sv
module prd_dma
   import prd_dma_pkg::*;
#(
   parameter int ADDR_W = 32,
   parameter int LEN_W  = 20,
   parameter int SEG_W  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [2:0]        reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              drv_req,
   input  logic [LEN_W-1:0]  drv_len,
   output logic              mem_req,
   output logic              mem_we,
   output logic              mem_word,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   input  logic              mem_ack,
   input  logic [31:0]       mem_rdata,
   input  logic              in_valid,
   input  logic [7:0]        in_data,
   output logic              in_ready,
   output logic              out_valid,
   output logic [7:0]        out_data,
   input  logic              out_ready,
   output logic              irq
);
   logic              go, stopped, dir, fin, fin_intr, fin_idle;
   logic [ADDR_W-1:0] tbl_base;

   prd_dma_regs #(.ADDR_W(ADDR_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(reg_we), .acc_addr(reg_addr),
      .wr_data(reg_wdata), .rd_data(reg_rdata), .fin(fin), .fin_intr(fin_intr),
      .fin_idle(fin_idle), .go(go), .stopped(stopped), .dir(dir),
      .tbl_base(tbl_base), .irq(irq)
   );

   prd_dma_engine #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .SEG_W(SEG_W)) u_engine (
      .clk(clk), .rst_n(rst_n), .go(go), .stopped(stopped), .dir(dir),
      .tbl_base(tbl_base), .drv_req(drv_req), .drv_len(drv_len),
      .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .fin(fin), .fin_intr(fin_intr), .fin_idle(fin_idle)
   );
endmodule

// File: tb/test_prd_dma.sv
module test_prd_dma;
   logic clk = 1'b0, rst_n = 1'b0;
   logic reg_we = 1'b0;
   logic [2:0] reg_addr = 3'd0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic drv_req = 1'b0;
   logic [19:0] drv_len = '0;
   logic mem_req, mem_we, mem_word, mem_ack;
   logic [31:0] mem_addr, mem_rdata;
   logic [7:0] mem_wdata;
   logic in_valid = 1'b0;
   logic [7:0] in_data = '0;
   logic in_ready, out_valid;
   logic [7:0] out_data;
   logic out_ready = 1'b1;
   logic irq;

   int total = 0, bad = 0;
   logic [7:0] mem [0:4095];
   logic [7:0] rx [0:255];
   int rx_n = 0;
   logic pl_we = 1'b0;
   logic [11:0] pl_a = '0;
   logic [7:0] pl_d = '0;
   logic ack_q = 1'b0;
   logic [31:0] rd_q = '0;

   always #2 clk = ~clk;

   prd_dma i_prd_dma (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .drv_req(drv_req),
      .drv_len(drv_len), .mem_req(mem_req), .mem_we(mem_we), .mem_word(mem_word),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
      .mem_rdata(mem_rdata), .in_valid(in_valid), .in_data(in_data),
      .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
      .out_ready(out_ready), .irq(irq)
   );

   assign mem_ack = ack_q;
   assign mem_rdata = rd_q;

   always @(posedge clk) begin
      logic [11:0] a;
      a = mem_addr[11:0];
      if (pl_we) mem[pl_a] = pl_d;
      if (mem_req && !ack_q) begin
         ack_q <= 1'b1;
         if (mem_we) mem[a] = mem_wdata;
         else if (mem_word)
            rd_q <= {mem[a + 12'd3], mem[a + 12'd2], mem[a + 12'd1], mem[a]};
         else rd_q <= {24'h0, mem[a]};
      end else ack_q <= 1'b0;
   end

   always @(negedge clk) begin
      if (out_valid && out_ready) begin
         rx[rx_n[7:0]] = out_data;
         rx_n = rx_n + 1;
      end
   end

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk); reg_we = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output int v);
      @(negedge clk); reg_addr = a; #1; v = int'(reg_rdata);
   endtask

   task automatic poke(input int a, input logic [7:0] d);
      @(negedge clk); pl_we = 1'b1; pl_a = 12'(a); pl_d = d;
      @(negedge clk); pl_we = 1'b0;
   endtask

   task automatic poke_word(input int a, input logic [31:0] w);
      for (int k = 0; k < 4; k++) poke(a + k, w[8*k +: 8]);
   endtask

   task automatic put_entry(input int a, input logic [31:0] base, input logic [31:0] cnt);
      poke_word(a, base);
      poke_word(a + 4, cnt);
   endtask

   task automatic clean();
      wr(3'd0, 32'h0);
      wr(3'd2, 32'h4);
   endtask

   task automatic feed(input int n, input logic [7:0] seed);
      for (int i = 0; i < n; i++) begin
         @(negedge clk); in_valid = 1'b1; in_data = seed + 8'(i);
         while (!in_ready) @(negedge clk);
         @(posedge clk);
      end
      @(negedge clk); in_valid = 1'b0;
   endtask

   task automatic xfer(input bit to_mem, input int n, input logic [7:0] seed);
      int base_n;
      base_n = rx_n;
      @(negedge clk); drv_req = 1'b1; drv_len = 20'(n);
      @(negedge clk); drv_req = 1'b0;
      if (to_mem) feed(n, seed);
      else while (rx_n - base_n < n) @(negedge clk);
      repeat (10) @(negedge clk);
   endtask

   task automatic t_reset();
      int v;
      rd(3'd0, v); chk("R1 cmd reset", v, 0);
      rd(3'd2, v); chk("R1 status reset", v, 0);
      rd(3'd4, v); chk("R1 ptr reset", v, 0);
      chk("R10 irq reset", int'(irq), 0);
   endtask

   task automatic t_exact_to_mem();
      int v;
      clean();
      put_entry(12'h100, 32'h800, 32'h8000_0010);
      wr(3'd4, 32'h102);
      rd(3'd4, v); chk("R2 ptr low bits ignored", v, 32'h100);
      wr(3'd0, 32'h9);
      rd(3'd2, v); chk("R1 start sets ACTIVE", v & 1, 1);
      rd(3'd0, v); chk("R1 cmd readback", v, 32'h9);
      xfer(1'b1, 16, 8'hA0);
      for (int i = 0; i < 16; i++) chk("R3 byte in memory", int'(mem[12'h800 + i]), 8'hA0 + i);
      rd(3'd2, v); chk("R5 exact status", v, 4);
      chk("R10 irq follows INTERRUPT", int'(irq), 1);
      wr(3'd2, 32'h4);
      rd(3'd2, v); chk("R10 W1C clears INTERRUPT", v, 0);
      chk("R10 irq cleared", int'(irq), 0);
   endtask

   task automatic t_two_entries_from_mem();
      int v, b;
      clean();
      put_entry(12'h200, 32'h600, 32'h0000_0008);
      put_entry(12'h208, 32'h700, 32'h8000_0008);
      for (int i = 0; i < 8; i++) begin
         poke(12'h600 + i, 8'h10 + 8'(i));
         poke(12'h700 + i, 8'h80 + 8'(i));
      end
      wr(3'd4, 32'h200);
      wr(3'd0, 32'h1);
      b = rx_n;
      xfer(1'b0, 16, 8'h00);
      for (int i = 0; i < 16; i++)
         chk("R4 order to drive", int'(rx[8'(b + i)]), i < 8 ? 8'h10 + i : 8'h80 + i - 8);
      rd(3'd2, v); chk("R5 exact status two entries", v, 4);
   endtask

   task automatic t_short();
      int v;
      clean();
      put_entry(12'h140, 32'h900, 32'h8000_0004);
      poke(12'h904, 8'hEE);
      wr(3'd4, 32'h140);
      wr(3'd0, 32'h9);
      xfer(1'b1, 12, 8'h40);
      for (int i = 0; i < 4; i++) chk("R6 short data", int'(mem[12'h900 + i]), 8'h40 + i);
      chk("R6 no write past table", int'(mem[12'h904]), 8'hEE);
      rd(3'd2, v); chk("R6 short status", v, 0);
      chk("R6 irq low", int'(irq), 0);
   endtask

   task automatic t_long();
      int v;
      clean();
      put_entry(12'h180, 32'hA00, 32'h8000_0040);
      wr(3'd4, 32'h180);
      wr(3'd0, 32'h9);
      xfer(1'b1, 16, 8'h20);
      chk("R7 long data last byte", int'(mem[12'hA0F]), 8'h2F);
      rd(3'd2, v); chk("R7 long status", v, 5);
      chk("R7 irq high", int'(irq), 1);
   endtask

   task automatic t_abort_long();
      int v;
      clean();
      put_entry(12'h1C0, 32'hB00, 32'h8000_0040);
      poke(12'hB00, 8'hEE);
      poke(12'hB0F, 8'hEE);
      wr(3'd4, 32'h1C0);
      wr(3'd0, 32'h9);
      wr(3'd0, 32'h8);
      rd(3'd2, v); chk("R8 stop clears ACTIVE", v, 0);
      xfer(1'b1, 16, 8'h55);
      chk("R8 no data write first", int'(mem[12'hB00]), 8'hEE);
      chk("R8 no data write last", int'(mem[12'hB0F]), 8'hEE);
      rd(3'd2, v); chk("R8 aborted long status", v, 4);
   endtask

   task automatic t_abort_short();
      int v;
      clean();
      put_entry(12'h1E0, 32'hC00, 32'h8000_0004);
      wr(3'd4, 32'h1E0);
      wr(3'd0, 32'h9);
      wr(3'd0, 32'h8);
      xfer(1'b1, 12, 8'h66);
      rd(3'd2, v); chk("R8 aborted short status", v, 0);
      chk("R8 aborted short irq", int'(irq), 0);
   endtask

   task automatic t_zero_count();
      int v, b;
      clean();
      put_entry(12'h400, 32'h500, 32'h8000_0000);
      for (int i = 0; i < 20; i++) poke(12'h500 + i, 8'h30 + 8'(i));
      wr(3'd4, 32'h400);
      wr(3'd0, 32'h1);
      b = rx_n;
      xfer(1'b0, 20, 8'h00);
      chk("R9 first byte", int'(rx[8'(b)]), 8'h30);
      chk("R9 last byte", int'(rx[8'(b + 19)]), 8'h43);
      rd(3'd2, v); chk("R9 zero count is 65536 so table is long", v, 5);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total + 1, bad + 1);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_exact_to_mem();
      t_two_entries_from_mem();
      t_short();
      t_long();
      t_abort_long();
      t_abort_short();
      t_zero_count();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule